// File: doc/BRIEF.md
# DDR2 Command Decoder with Clock-Enable Tracking

This block watches the control pins of a DDR2 memory device at each rising clock edge and turns each sampled pin pattern into a one-hot command strobe. The inputs are chip select, the three command strobes, clock enable, the bank address and address bit A10. It keeps its own copy of the clock-enable value from the previous edge. With that copy it tells apart auto refresh from self-refresh entry, and a plain no-operation from power-down entry. It also tracks whether the device is active, powered down or in self-refresh.

Bank address bit 0 and A10 refine the decode. Bank bit 0 separates the mode register from the extended mode register. A10 separates single-bank precharge from precharge of all banks, and plain column access from access with auto-precharge. A small burst tracker remembers the type of the last column command and how many clocks its data burst lasts. A column command of the other type inside that window raises an illegal-interruption flag.

All outputs are registered. The pins are a free-running sample with no way to stall, so the block has no valid/ready handshake and applies no back-pressure. Each strobe is valid for exactly the one clock that follows the edge that sampled it.

Top module: `ddr2_cmd_decoder`

## Requirements
- R1: The pins are sampled at the rising edge only. Each decoded result appears on the registered outputs after that same edge and lasts one clock. `cmd_oh` never has more than one bit set.
- R2: When clock enable is high at both the previous and the current edge and `cs_n` is low, {`ras_n`,`cas_n`,`we_n`} decodes as follows: 000 → mode set (bit 0), 001 → refresh (bit 1), 010 → precharge (bit 4), 011 → activate (bit 5), 100 → write (bit 6), 101 → read (bit 7), 111 → no-op (bit 8). The reserved code 110 gives no strobe.
- R3: With `cs_n` high and clock enable high at both edges, the result is deselect (bit 9) whatever the other pins show, and `cmd_bank` reads 0.
- R4: For a mode set, `cmd_ext` equals `ba[0]`: 0 selects the base mode register and 1 selects the extended one. `cmd_ext` is 0 for every other command.
- R5: For a precharge with A10 low, `cmd_bank` carries `ba` and `cmd_a10` is 0. With A10 high, all banks are meant: `cmd_a10` is 1 and `cmd_bank` is 0.
- R6: For read or write, `cmd_bank` carries `ba` and `cmd_a10` carries A10, where 1 means auto-precharge. Activate also carries `ba`.
- R7: The refresh code with clock enable high at the previous edge and low at the current edge gives self-refresh entry (bit 2). `pwr_state` then reads 2. `pwr_state` encodes 0 as active, 1 as power-down and 2 as self-refresh.
- R8: No-op or deselect with clock enable high at the previous edge and low at the current edge gives power-down entry (bit 10), and `pwr_state` then reads 1. Any other code on that falling clock enable gives no strobe and leaves the state active.
- R9: In power-down, clock enable sampled high together with no-op or deselect gives power-down exit (bit 11), and the state returns to active. Every other pattern in power-down gives no strobe.
- R10: In self-refresh, clock enable sampled high gives self-refresh exit (bit 3) and a return to active, whatever the command pins show. While clock enable stays low, no strobe is given.
- R11: A read or write opens a burst window of 2 clocks when `bl8` is 0 and 4 clocks when `bl8` is 1. The window covers the edges that follow the issuing edge. After the window closes, any column command is legal.
- R12: A column command of the opposite type inside the window pulses `burst_illegal` along with its own strobe. A command of the same type does not, and it restarts the window.
- R13: Reset makes the state active, clears the stored clock enable to low and clears all outputs. While in the active state, an edge whose previous clock enable was low gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BANK_W | Bank address |
| a10 | input | 1 | Address bit 10 (all-banks / auto-precharge) |
| bl8 | input | 1 | Burst length select: 0 = 4, 1 = 8 |
| cmd_oh | output | 12 | One-hot command strobe |
| cmd_bank | output | BANK_W | Bank of the decoded command |
| cmd_a10 | output | 1 | Precharge-all or auto-precharge flag |
| cmd_ext | output | 1 | Extended mode register select |
| pwr_state | output | 2 | 0 active, 1 power-down, 2 self-refresh |
| burst_illegal | output | 1 | Burst interrupted by the wrong column type |

## Verification
The decode is driven with every command code at steady clock enable, with the reserved code, and with chip select high over busy pins. This separates each strobe position and the bank, A10 and bank-0 refinements. The same codes are then sent on a falling and on a rising clock enable, which separates auto refresh from self-refresh entry and no-op from power-down entry. It also shows that non-qualifying codes are suppressed in each power state. Column sequences at window positions 1, 2 and 4 for both burst lengths, plus same-type and post-window cases, mark the exact edges of the illegal-interruption window.

// File: rtl/ddr2_cmd_pkg.sv
package ddr2_cmd_pkg;

  // Internal command kinds; K_NONE means no strobe this cycle.
  typedef enum logic [3:0] {
    K_NONE = 4'd0,
    K_MRS  = 4'd1,
    K_REF  = 4'd2,
    K_SRE  = 4'd3,
    K_SRX  = 4'd4,
    K_PRE  = 4'd5,
    K_ACT  = 4'd6,
    K_WR   = 4'd7,
    K_RD   = 4'd8,
    K_NOP  = 4'd9,
    K_DESL = 4'd10,
    K_PDE  = 4'd11,
    K_PDX  = 4'd12
  } cmd_kind_e;

  // One-hot bit of each kind is its code minus one.
  localparam int NUM_CMD = 12;
  localparam int B_MRS   = 0;
  localparam int B_REF   = 1;
  localparam int B_SRE   = 2;
  localparam int B_SRX   = 3;
  localparam int B_PRE   = 4;
  localparam int B_ACT   = 5;
  localparam int B_WR    = 6;
  localparam int B_RD    = 7;
  localparam int B_NOP   = 8;
  localparam int B_DESL  = 9;
  localparam int B_PDE   = 10;
  localparam int B_PDX   = 11;

  typedef enum logic [1:0] {
    PWR_ACT  = 2'd0,
    PWR_PDN  = 2'd1,
    PWR_SREF = 2'd2
  } pwr_e;

  // {ras_n, cas_n, we_n} with chip select low
  localparam logic [2:0] OP_MODE = 3'b000;
  localparam logic [2:0] OP_REFR = 3'b001;
  localparam logic [2:0] OP_PREC = 3'b010;
  localparam logic [2:0] OP_ACTV = 3'b011;
  localparam logic [2:0] OP_WRIT = 3'b100;
  localparam logic [2:0] OP_READ = 3'b101;
  localparam logic [2:0] OP_IDLE = 3'b111;

endpackage

// File: rtl/ddr2_pin_decode.sv
module ddr2_pin_decode
  import ddr2_cmd_pkg::*;
(
  input  logic      cs_n,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  input  logic      cke,
  input  logic      cke_prev,
  input  pwr_e      pwr,
  output cmd_kind_e kind
);

  logic [2:0] op;
  logic       idle_like;

  assign op        = {ras_n, cas_n, we_n};
  assign idle_like = cs_n | (op == OP_IDLE);

  always_comb begin
    kind = K_NONE;
    unique case (pwr)
      PWR_SREF: begin
        // exit does not depend on the command pins
        if (cke) kind = K_SRX;
      end
      PWR_PDN: begin
        if (cke && idle_like) kind = K_PDX;
      end
      default: begin
        if (cke_prev) begin
          if (cke) begin
            if (cs_n) begin
              kind = K_DESL;
            end else begin
              unique case (op)
                OP_MODE: kind = K_MRS;
                OP_REFR: kind = K_REF;
                OP_PREC: kind = K_PRE;
                OP_ACTV: kind = K_ACT;
                OP_WRIT: kind = K_WR;
                OP_READ: kind = K_RD;
                OP_IDLE: kind = K_NOP;
                default: kind = K_NONE;
              endcase
            end
          end else if (!cs_n && op == OP_REFR) begin
            kind = K_SRE;
          end else if (idle_like) begin
            kind = K_PDE;
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/ddr2_pwr_track.sv
module ddr2_pwr_track
  import ddr2_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cke,
  input  cmd_kind_e kind,
  output logic      cke_prev,
  output pwr_e      pwr
);

  pwr_e pwr_next;

  always_comb begin
    pwr_next = pwr;
    unique case (kind)
      K_SRE:        pwr_next = PWR_SREF;
      K_PDE:        pwr_next = PWR_PDN;
      K_SRX, K_PDX: pwr_next = PWR_ACT;
      default:      pwr_next = pwr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_prev <= 1'b0;
      pwr      <= PWR_ACT;
    end else begin
      cke_prev <= cke;
      pwr      <= pwr_next;
    end
  end

endmodule

// File: rtl/ddr2_burst_watch.sv
module ddr2_burst_watch
  import ddr2_cmd_pkg::*;
#(
  parameter int SHORT_BL = 4,
  parameter int LONG_BL  = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bl8,
  input  cmd_kind_e kind,
  output logic      illegal
);

  localparam int SHORT_CLK = SHORT_BL / 2;
  localparam int LONG_CLK  = LONG_BL / 2;
  localparam int MAX_CLK   = (LONG_CLK > SHORT_CLK) ? LONG_CLK : SHORT_CLK;
  localparam int CNT_W     = $clog2(MAX_CLK + 1);

  logic [CNT_W-1:0] remain;
  logic             burst_wr;
  logic             col_cmd;
  logic             col_wr;
  logic [CNT_W-1:0] load_val;

  assign col_cmd  = (kind == K_RD) || (kind == K_WR);
  assign col_wr   = (kind == K_WR);
  assign load_val = bl8 ? CNT_W'(LONG_CLK) : CNT_W'(SHORT_CLK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain   <= '0;
      burst_wr <= 1'b0;
      illegal  <= 1'b0;
    end else if (col_cmd) begin
      illegal  <= (remain != '0) && (col_wr != burst_wr);
      remain   <= load_val;
      burst_wr <= col_wr;
    end else begin
      illegal  <= 1'b0;
      if (remain != '0) remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/ddr2_cmd_decoder.sv
module ddr2_cmd_decoder
  import ddr2_cmd_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int SHORT_BL = 4,
  parameter int LONG_BL  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              cke,
  input  logic [BANK_W-1:0] ba,
  input  logic              a10,
  input  logic              bl8,
  output logic [11:0]       cmd_oh,
  output logic [BANK_W-1:0] cmd_bank,
  output logic              cmd_a10,
  output logic              cmd_ext,
  output logic [1:0]        pwr_state,
  output logic              burst_illegal
);

  cmd_kind_e           kind;
  logic                cke_prev;
  pwr_e                pwr;
  logic [NUM_CMD-1:0]  oh_next;
  logic [BANK_W-1:0]   bank_next;
  logic                a10_next;
  logic                ext_next;
  logic                banked;

  ddr2_pin_decode u_dec (
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .cke      (cke),
    .cke_prev (cke_prev),
    .pwr      (pwr),
    .kind     (kind)
  );

  ddr2_pwr_track u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .kind     (kind),
    .cke_prev (cke_prev),
    .pwr      (pwr)
  );

  ddr2_burst_watch #(
    .SHORT_BL (SHORT_BL),
    .LONG_BL  (LONG_BL)
  ) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .bl8     (bl8),
    .kind    (kind),
    .illegal (burst_illegal)
  );

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_oh
    assign oh_next[g] = (kind == cmd_kind_e'(g + 1));
  end

  assign banked    = (kind == K_ACT) || (kind == K_RD) || (kind == K_WR) ||
                     ((kind == K_PRE) && !a10);
  assign bank_next = banked ? ba : '0;
  assign a10_next  = a10 && ((kind == K_PRE) || (kind == K_RD) || (kind == K_WR));
  assign ext_next  = (kind == K_MRS) && ba[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_oh   <= '0;
      cmd_bank <= '0;
      cmd_a10  <= 1'b0;
      cmd_ext  <= 1'b0;
    end else begin
      cmd_oh   <= oh_next;
      cmd_bank <= bank_next;
      cmd_a10  <= a10_next;
      cmd_ext  <= ext_next;
    end
  end

  assign pwr_state = pwr;

endmodule

// File: rtl/ddr2_cmd_decoder_chk.sv
module ddr2_cmd_decoder_chk
  import ddr2_cmd_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cke,
  input logic [11:0] cmd_oh,
  input logic        cmd_a10,
  input logic        cmd_ext,
  input logic [1:0]  pwr_state,
  input logic        burst_illegal
);

  localparam logic [11:0] PDX_ONLY = 12'(1) << B_PDX;

  // R1: never two strobes at once
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_oh));

  // R4: extended select only accompanies a mode set
  p_ext_mrs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ext |-> cmd_oh[B_MRS]);

  // R5: the A10 flag only on precharge, read or write
  p_a10_cols_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_a10 |-> (cmd_oh[B_PRE] || cmd_oh[B_RD] || cmd_oh[B_WR]));

  // R7: self-refresh entry strobe comes with the new state
  p_sref_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oh[B_SRE] |-> (pwr_state == PWR_SREF));

  // R9: in power-down only the exit strobe may follow
  p_pdn_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PWR_PDN) |=> ((cmd_oh & ~PDX_ONLY) == 12'd0));

  // R10: clock enable high in self-refresh always leaves it
  p_sref_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PWR_SREF && cke) |=> (cmd_oh[B_SRX] && pwr_state == PWR_ACT));

  // R12: the illegal flag rides on a column strobe
  p_illegal_col_r12: assert property (@(posedge clk) disable iff (!rst_n)
    burst_illegal |-> (cmd_oh[B_RD] || cmd_oh[B_WR]));

endmodule

bind ddr2_cmd_decoder ddr2_cmd_decoder_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cke           (cke),
  .cmd_oh        (cmd_oh),
  .cmd_a10       (cmd_a10),
  .cmd_ext       (cmd_ext),
  .pwr_state     (pwr_state),
  .burst_illegal (burst_illegal)
);

// File: tb/ddr2_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module ddr2_cmd_decoder_tb_top;

  localparam logic [3:0] P_MRS = 4'b0000;
  localparam logic [3:0] P_REF = 4'b0001;
  localparam logic [3:0] P_PRE = 4'b0010;
  localparam logic [3:0] P_ACT = 4'b0011;
  localparam logic [3:0] P_WR  = 4'b0100;
  localparam logic [3:0] P_RD  = 4'b0101;
  localparam logic [3:0] P_RSV = 4'b0110;
  localparam logic [3:0] P_NOP = 4'b0111;
  localparam logic [3:0] P_DSB = 4'b1000;  // chip select high, busy pins
  localparam logic [3:0] P_DES = 4'b1111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic        cke = 1'b0;
  logic [1:0]  ba = 2'd0;
  logic        a10 = 1'b0;
  logic        bl8 = 1'b0;
  logic [11:0] cmd_oh;
  logic [1:0]  cmd_bank;
  logic        cmd_a10, cmd_ext, burst_illegal;
  logic [1:0]  pwr_state;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit done     = 0;

  typedef struct {
    int          due;
    logic [11:0] oh;
    logic [1:0]  bank;
    logic        fa10;
    logic        ext;
    logic [1:0]  pwr;
    logic        ill;
    string       req;
  } exp_t;

  exp_t sb_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr2_cmd_decoder dut_i (
    .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
    .we_n (we_n), .cke (cke), .ba (ba), .a10 (a10), .bl8 (bl8),
    .cmd_oh (cmd_oh), .cmd_bank (cmd_bank), .cmd_a10 (cmd_a10),
    .cmd_ext (cmd_ext), .pwr_state (pwr_state), .burst_illegal (burst_illegal)
  );

  // driver: called at a falling edge, drives pins and queues the expectation
  task automatic step(input logic [3:0] pins, input logic cke_v,
                      input logic [1:0] ba_v, input logic a10_v,
                      input int ebit, input logic [1:0] ebank,
                      input logic ea10, input logic eext,
                      input logic [1:0] epwr, input logic eill,
                      input string req);
    exp_t e;
    {cs_n, ras_n, cas_n, we_n} = pins;
    cke = cke_v;
    ba  = ba_v;
    a10 = a10_v;
    e.due  = cyc + 1;
    e.oh   = (ebit < 0) ? 12'd0 : (12'd1 << ebit);
    e.bank = ebank;
    e.fa10 = ea10;
    e.ext  = eext;
    e.pwr  = epwr;
    e.ill  = eill;
    e.req  = req;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: pops one expectation per clock and compares
  always @(negedge clk) begin
    if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (cmd_oh !== e.oh || cmd_bank !== e.bank || cmd_a10 !== e.fa10 ||
          cmd_ext !== e.ext || pwr_state !== e.pwr || burst_illegal !== e.ill) begin
        n_fails++;
        $display("FAIL %s: got oh=%h bank=%0d a10=%b ext=%b pwr=%0d ill=%b, expected oh=%h bank=%0d a10=%b ext=%b pwr=%0d ill=%b",
                 e.req, cmd_oh, cmd_bank, cmd_a10, cmd_ext, pwr_state, burst_illegal,
                 e.oh, e.bank, e.fa10, e.ext, e.pwr, e.ill);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    n_checks++;
    if (cmd_oh !== 12'd0 || pwr_state !== 2'd0 || burst_illegal !== 1'b0) begin
      n_fails++;
      $display("FAIL R13 reset: got oh=%h pwr=%0d ill=%b, expected 000 0 0",
               cmd_oh, pwr_state, burst_illegal);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R13: stored clock enable is low after reset, so no strobe
    step(P_NOP, 1, 0, 0, -1, 0, 0, 0, 0, 0, "R13 first edge");
    // R2 base decode
    step(P_NOP, 1, 0, 0, 8, 0, 0, 0, 0, 0, "R2 nop");
    step(P_MRS, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R4 base mode");
    step(P_MRS, 1, 1, 0, 0, 0, 0, 1, 0, 0, "R4 extended mode");
    step(P_REF, 1, 0, 0, 1, 0, 0, 0, 0, 0, "R7 auto refresh");
    step(P_ACT, 1, 2, 0, 5, 2, 0, 0, 0, 0, "R6 activate bank");
    step(P_PRE, 1, 3, 0, 4, 3, 0, 0, 0, 0, "R5 single precharge");
    step(P_PRE, 1, 3, 1, 4, 0, 1, 0, 0, 0, "R5 precharge all");
    step(P_DSB, 1, 3, 1, 9, 0, 0, 0, 0, 0, "R3 deselect");
    step(P_RSV, 1, 0, 0, -1, 0, 0, 0, 0, 0, "R2 reserved code");

    // R11/R12 with burst length 4 (window 2)
    step(P_RD,  1, 1, 1, 7, 1, 1, 0, 0, 0, "R6 read auto-precharge");
    step(P_RD,  1, 1, 0, 7, 1, 0, 0, 0, 0, "R12 read on read");
    step(P_WR,  1, 0, 0, 6, 0, 0, 0, 0, 1, "R12 write on read");
    step(P_NOP, 1, 0, 0, 8, 0, 0, 0, 0, 0, "R11 gap");
    step(P_NOP, 1, 0, 0, 8, 0, 0, 0, 0, 0, "R11 gap");
    step(P_RD,  1, 2, 0, 7, 2, 0, 0, 0, 0, "R11 after short window");
    step(P_NOP, 1, 0, 0, 8, 0, 0, 0, 0, 0, "R11 gap");
    step(P_WR,  1, 2, 1, 6, 2, 1, 0, 0, 1, "R11 last clock of short window");
    step(P_NOP, 1, 0, 0, 8, 0, 0, 0, 0, 0, "R11 gap");
    step(P_NOP, 1, 0, 0, 8, 0, 0, 0, 0, 0, "R11 gap");

    // burst length 8 (window 4)
    bl8 = 1'b1;
    step(P_WR,  1, 2, 0, 6, 2, 0, 0, 0, 0, "R11 long write");
    step(P_NOP, 1, 0, 0, 8, 0, 0, 0, 0, 0, "R11 gap");
    step(P_NOP, 1, 0, 0, 8, 0, 0, 0, 0, 0, "R11 gap");
    step(P_NOP, 1, 0, 0, 8, 0, 0, 0, 0, 0, "R11 gap");
    step(P_RD,  1, 1, 0, 7, 1, 0, 0, 0, 1, "R11 last clock of long window");
    for (int i = 0; i < 4; i++) step(P_NOP, 1, 0, 0, 8, 0, 0, 0, 0, 0, "R11 gap");
    step(P_WR,  1, 3, 0, 6, 3, 0, 0, 0, 0, "R11 after long window");
    for (int i = 0; i < 4; i++) step(P_NOP, 1, 0, 0, 8, 0, 0, 0, 0, 0, "R11 gap");

    // power-down
    step(P_NOP, 0, 0, 0, 10, 0, 0, 0, 1, 0, "R8 power-down entry");
    step(P_ACT, 0, 1, 0, -1, 0, 0, 0, 1, 0, "R9 suppressed in power-down");
    step(P_RD,  1, 1, 0, -1, 0, 0, 0, 1, 0, "R9 no exit on read");
    step(P_DES, 1, 0, 0, 11, 0, 0, 0, 0, 0, "R9 power-down exit");
    step(P_ACT, 1, 1, 0, 5, 1, 0, 0, 0, 0, "R2 activate after exit");
    step(P_ACT, 0, 1, 0, -1, 0, 0, 0, 0, 0, "R8 activate on falling enable");
    step(P_NOP, 1, 0, 0, -1, 0, 0, 0, 0, 0, "R13 previous enable low");

    // self-refresh
    step(P_NOP, 1, 0, 0, 8, 0, 0, 0, 0, 0, "R2 nop");
    step(P_REF, 0, 0, 0, 2, 0, 0, 0, 2, 0, "R7 self-refresh entry");
    step(P_REF, 0, 0, 0, -1, 0, 0, 0, 2, 0, "R10 hold in self-refresh");
    step(P_DES, 0, 0, 0, -1, 0, 0, 0, 2, 0, "R10 hold in self-refresh");
    step(P_ACT, 1, 2, 1, 3, 0, 0, 0, 0, 0, "R10 exit on any pins");
    step(P_NOP, 1, 0, 0, 8, 0, 0, 0, 0, 0, "R1 active again");
    step(P_DES, 0, 0, 0, 10, 0, 0, 0, 1, 0, "R8 entry on deselect");
    step(P_NOP, 1, 0, 0, 11, 0, 0, 0, 0, 0, "R9 exit on nop");
    step(P_DES, 1, 0, 0, 9, 0, 0, 0, 0, 0, "R1 one-clock strobe");

    repeat (3) @(negedge clk);
    n_checks++;
    if (sb_q.size() != 0) begin
      n_fails++;
      $display("FAIL R1 scoreboard drain: got %0d left, expected 0", sb_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule